// File: doc/BRIEF.md
# GPIO Pin Event Interrupt Detector

This block watches the 32 input pins of a general-purpose I/O bank and turns selected pin conditions into interrupts. Each pin has four separately enabled detect conditions (level low, level high, rising edge and falling edge). When any enabled condition is present on the synchronized pin, the pin's bit is recorded in a per-line raw event register. Two interrupt lines are provided, each with its own enable mask and its own write-one-to-clear status view, so one line can serve the main processor and the other a second agent.

Software reaches the block over the bank's simple register bus: a select, a write strobe, a byte address, write data and a combinational read data return. Line enables are never written directly; they are changed through separate write-one-to-set and write-one-to-clear addresses, so two agents can change different bits without a read-modify-write race. Adding a new detect condition before removing an old one keeps an event that arrives during reconfiguration from being lost.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every detect-enable register, line enable mask and raw event register reads zero and both `irq_o` bits are low.
- R2: The detect-enable registers are read/write at byte offsets 0x140 (level low), 0x144 (level high), 0x148 (rising edge) and 0x14C (falling edge); bit i controls pin i.
- R3: Pins pass through a two-stage synchronizer; a level condition sets the pin's raw bit on every cycle it holds, so the bit is readable after the third rising clock edge following the pin change and re-sets immediately after a clear while the level persists.
- R4: An edge condition sets the raw bit once, on the cycle the synchronized input changes in the enabled direction; once cleared the bit stays clear until the next such change.
- R5: A pin's event condition is the OR of all its enabled conditions, and a detect-enable write takes effect on the next cycle, so enabling a new condition before disabling an old one catches an event arriving in between.
- R6: Raw events are readable at 0x024 (line 0) and 0x028 (line 1) regardless of the line's enable mask; status at 0x02C (line 0) and 0x030 (line 1) reads raw AND enable mask.
- R7: Writing to a status offset clears the raw bits of that line where the write data is 1; 0 bits leave the raw bits unchanged.
- R8: Writing to 0x034/0x038 sets, and to 0x03C/0x040 clears, the enable bits of line 0/1 where the write data is 1; 0 bits have no effect, and reading any of these four offsets returns that line's current enable mask.
- R9: `irq_o[k]` is high exactly one cycle after a cycle in which line k has any bit with both raw and enable set.
- R10: When a clear write and a new event hit the same raw bit in the same cycle, the bit stays set.
- R11: Writes to raw offsets or to unmapped offsets change no state, and unmapped offsets and idle cycles read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 32 | Asynchronous pin levels |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 2 | Registered interrupt lines 0 and 1 |

## Verification
The bench aims at the collision of a status clear with a live level condition, where a design letting the clear win would drop a held interrupt for one cycle and show a zero raw bit. It checks that an edge bit stays clear after acknowledgement, which a design treating edges as levels would fail by re-asserting at once. It reconfigures a pin from falling to rising detection with both briefly enabled, catching a design that applies detect writes late, and writes zero bits to every alias, catching a design that copies write data instead of acting only on ones. Random traffic compared with a cycle model covers the synchronizer latency and the one-cycle interrupt delay.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W    = 9;
  localparam int NUM_LINES = 2;
  localparam int NUM_DET   = 4;

  // Per-line register banks; line k sits at base + 4*k.
  localparam logic [ADDR_W-1:0] OFF_RAW_BASE = 9'h024;
  localparam logic [ADDR_W-1:0] OFF_STS_BASE = 9'h02C;
  localparam logic [ADDR_W-1:0] OFF_SET_BASE = 9'h034;
  localparam logic [ADDR_W-1:0] OFF_CLR_BASE = 9'h03C;

  // Detect-enable registers, indexed by det_kind_e.
  localparam logic [ADDR_W-1:0] OFF_DET_BASE = 9'h140;

  typedef enum logic [1:0] {
    DET_LVL_LO = 2'd0,
    DET_LVL_HI = 2'd1,
    DET_RISE   = 2'd2,
    DET_FALL   = 2'd3
  } det_kind_e;

  function automatic logic [ADDR_W-1:0] bank_off(input logic [ADDR_W-1:0] base,
                                                 input int idx);
    return base + ADDR_W'(4 * idx);
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_cur,
  output logic [W-1:0] pin_prev
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= pin_in;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign pin_cur  = stage_q[STAGES-1];
  assign pin_prev = prev_q;

endmodule

// File: rtl/gpio_irq_event.sv
module gpio_irq_event
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [NUM_DET-1:0][W-1:0] det_en,
  input  logic [W-1:0]              pin_cur,
  input  logic [W-1:0]              pin_prev,
  output logic [W-1:0]              evt
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      logic lvl_lo, lvl_hi, edge_up, edge_dn;
      assign lvl_lo  = det_en[DET_LVL_LO][i] & ~pin_cur[i];
      assign lvl_hi  = det_en[DET_LVL_HI][i] &  pin_cur[i];
      assign edge_up = det_en[DET_RISE][i]   &  pin_cur[i] & ~pin_prev[i];
      assign edge_dn = det_en[DET_FALL][i]   & ~pin_cur[i] &  pin_prev[i];
      assign evt[i]  = lvl_lo | lvl_hi | edge_up | edge_dn;
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         wr_sts,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] en_q,
  output logic         irq_q
);

  logic [W-1:0] raw_d, en_d, ack_mask;
  logic         raw_ce, en_ce, irq_d;

  always_comb begin
    ack_mask = wr_sts ? wdata : '0;
    raw_d    = (raw_q & ~ack_mask) | evt;
    raw_ce   = wr_sts | (|evt);
    en_d     = en_q;
    if (wr_set) en_d = en_d | wdata;
    if (wr_clr) en_d = en_d & ~wdata;
    en_ce    = wr_set | wr_clr;
    irq_d    = |(raw_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (raw_ce) raw_q <= raw_d;
      if (en_ce)  en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  output logic [NUM_LINES-1:0] irq_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  // Pin synchronizer
  logic [NUM_PINS-1:0] pin_cur, pin_prev;

  gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pin_in   (pin_in),
    .pin_cur  (pin_cur),
    .pin_prev (pin_prev)
  );

  // Detect-enable registers
  logic [NUM_DET-1:0][NUM_PINS-1:0] det_q, det_d;
  logic [NUM_DET-1:0]               det_we;

  always_comb begin
    for (int d = 0; d < NUM_DET; d++) begin
      det_we[d] = wr_en && (bus_addr == bank_off(OFF_DET_BASE, d));
      det_d[d]  = det_we[d] ? bus_wdata : det_q[d];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) det_q <= '0;
    else if (|det_we) det_q <= det_d;
  end

  // Event detection
  logic [NUM_PINS-1:0] evt;

  gpio_irq_event #(.W(NUM_PINS)) u_event (
    .det_en   (det_q),
    .pin_cur  (pin_cur),
    .pin_prev (pin_prev),
    .evt      (evt)
  );

  // Interrupt lines
  logic [NUM_LINES-1:0][NUM_PINS-1:0] raw_q, en_q;
  logic [NUM_LINES-1:0]               wr_sts, wr_set, wr_clr;

  genvar k;
  generate
    for (k = 0; k < NUM_LINES; k++) begin : g_line
      assign wr_sts[k] = wr_en && (bus_addr == bank_off(OFF_STS_BASE, k));
      assign wr_set[k] = wr_en && (bus_addr == bank_off(OFF_SET_BASE, k));
      assign wr_clr[k] = wr_en && (bus_addr == bank_off(OFF_CLR_BASE, k));

      gpio_irq_line #(.W(NUM_PINS)) u_line (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .evt    (evt),
        .wr_sts (wr_sts[k]),
        .wr_set (wr_set[k]),
        .wr_clr (wr_clr[k]),
        .wdata  (bus_wdata),
        .raw_q  (raw_q[k]),
        .en_q   (en_q[k]),
        .irq_q  (irq_o[k])
      );
    end
  endgenerate

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      for (int d = 0; d < NUM_DET; d++)
        if (bus_addr == bank_off(OFF_DET_BASE, d)) bus_rdata = det_q[d];
      for (int l = 0; l < NUM_LINES; l++) begin
        if (bus_addr == bank_off(OFF_RAW_BASE, l)) bus_rdata = raw_q[l];
        if (bus_addr == bank_off(OFF_STS_BASE, l)) bus_rdata = raw_q[l] & en_q[l];
        if (bus_addr == bank_off(OFF_SET_BASE, l)) bus_rdata = en_q[l];
        if (bus_addr == bank_off(OFF_CLR_BASE, l)) bus_rdata = en_q[l];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [W-1:0]                 bus_wdata,
  input logic [W-1:0]                 evt,
  input logic [NUM_LINES-1:0][W-1:0]  raw_q,
  input logic [NUM_LINES-1:0][W-1:0]  en_q,
  input logic [NUM_LINES-1:0]         irq_o
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (irq_o == '0 && raw_q == '0 && en_q == '0);
    end
  end

  // R10
  event_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q[0] & $past(evt)) == $past(evt)));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_STS_BASE) |=>
      ((raw_q[0] & $past(bus_wdata & ~evt)) == '0));

  // R8
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_SET_BASE) |=>
      ((en_q[0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R8
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFF_CLR_BASE) |=> ((en_q[0] & $past(bus_wdata)) == '0));

  // R9
  irq0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[0] == $past(|(raw_q[0] & en_q[0]))));

  // R9
  irq1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o[1] == $past(|(raw_q[1] & en_q[1]))));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .wr_en     (wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt       (evt),
  .raw_q     (raw_q),
  .en_q      (en_q),
  .irq_o     (irq_o)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  import gpio_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_in;
  logic        bus_sel, bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_o;

  always #10 clk = ~clk;

  gpio_irq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference model state
  logic [31:0] m_s1, m_s2, m_p;
  logic [3:0][31:0] m_det;
  logic [1:0][31:0] m_raw, m_en;
  logic [1:0] m_irq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [8:0] a);
    logic [31:0] r = '0;
    for (int d = 0; d < 4; d++) if (a == 9'h140 + 9'(4*d)) r = m_det[d];
    for (int l = 0; l < 2; l++) begin
      if (a == 9'h024 + 9'(4*l)) r = m_raw[l];
      if (a == 9'h02C + 9'(4*l)) r = m_raw[l] & m_en[l];
      if (a == 9'h034 + 9'(4*l)) r = m_en[l];
      if (a == 9'h03C + 9'(4*l)) r = m_en[l];
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [8:0] a);
    if (a >= 9'h140 && a <= 9'h14C) return "R2";
    if (a == 9'h024 || a == 9'h028) return "R6";
    if (a == 9'h02C || a == 9'h030) return "R7";
    if (a >= 9'h034 && a <= 9'h040) return "R8";
    return "R11";
  endfunction

  task automatic model_step(input logic w, input logic [8:0] a, input logic [31:0] d);
    logic [31:0] ev;
    ev = (m_det[0] & ~m_s2) | (m_det[1] & m_s2) |
         (m_det[2] & m_s2 & ~m_p) | (m_det[3] & ~m_s2 & m_p);
    for (int l = 0; l < 2; l++) begin
      m_irq[l] = |(m_raw[l] & m_en[l]);
      if (w && a == 9'h02C + 9'(4*l)) m_raw[l] = m_raw[l] & ~d;
      m_raw[l] = m_raw[l] | ev;
      if (w && a == 9'h034 + 9'(4*l)) m_en[l] = m_en[l] | d;
      if (w && a == 9'h03C + 9'(4*l)) m_en[l] = m_en[l] & ~d;
    end
    for (int k = 0; k < 4; k++) if (w && a == 9'h140 + 9'(4*k)) m_det[k] = d;
    m_p = m_s2; m_s2 = m_s1; m_s1 = pin_in;
  endtask

  // One bus cycle, started at a falling edge; returns read data.
  task automatic cyc(input logic s, input logic w, input logic [8:0] a,
                     input logic [31:0] d, output logic [31:0] rd);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    rd = bus_rdata;
    if (s && !w) chk({tag_of(a), " model"}, rd, m_read(a));
    @(posedge clk);
    model_step(s & w, a, d);
    @(negedge clk);
    chk("R9 irq", {30'd0, irq_o}, {30'd0, m_irq});
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] rd;
    cyc(1'b1, 1'b1, a, d, rd);
  endtask

  task automatic rd_exp(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] rd;
    cyc(1'b1, 1'b0, a, 32'd0, rd);
    chk(tag, rd, exp);
  endtask

  task automatic idle(input int n);
    logic [31:0] rd;
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 9'd0, 32'd0, rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED_1234));
    m_s1 = '0; m_s2 = '0; m_p = '0; m_det = '0; m_raw = '0; m_en = '0; m_irq = '0;
    rst_n = 1'b0; pin_in = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 irq", {30'd0, irq_o}, 32'd0);
    for (int a = 0; a < 4; a++) rd_exp("R1 det", 9'h140 + 9'(4*a), 32'd0);
    for (int a = 0; a < 8; a++) rd_exp("R1 line", 9'h024 + 9'(4*a), 32'd0);

    // R2: detect-enable read/write
    wr(9'h140, 32'hA5A5_0001); wr(9'h144, 32'h0F0F_0002);
    wr(9'h148, 32'h1234_5678); wr(9'h14C, 32'h8000_0004);
    rd_exp("R2 lvl_lo", 9'h140, 32'hA5A5_0001);
    rd_exp("R2 lvl_hi", 9'h144, 32'h0F0F_0002);
    rd_exp("R2 rise",   9'h148, 32'h1234_5678);
    rd_exp("R2 fall",   9'h14C, 32'h8000_0004);
    for (int a = 0; a < 4; a++) wr(9'h140 + 9'(4*a), 32'd0);
    idle(2);
    wr(9'h024, 32'hFFFF_FFFF); wr(9'h02C, 32'hFFFF_FFFF);
    wr(9'h028, 32'hFFFF_FFFF); wr(9'h030, 32'hFFFF_FFFF);

    // R8: set/clear aliases
    wr(9'h034, 32'h0000_00F0);
    rd_exp("R8 set read via clr", 9'h03C, 32'h0000_00F0);
    wr(9'h03C, 32'h0000_0030);
    rd_exp("R8 clr", 9'h034, 32'h0000_00C0);
    wr(9'h034, 32'h0); wr(9'h03C, 32'h0);
    rd_exp("R8 zero writes", 9'h034, 32'h0000_00C0);
    rd_exp("R8 line1 untouched", 9'h038, 32'h0);

    // R4 / R6: rising edge on pin 4, not enabled on line 0
    wr(9'h148, 32'h0000_0010);
    pin_in[4] = 1'b1;
    idle(3);
    rd_exp("R6 raw without enable", 9'h024, 32'h0000_0010);
    rd_exp("R6 status masked", 9'h02C, 32'h0);
    rd_exp("R6 raw line1", 9'h028, 32'h0000_0010);
    wr(9'h030, 32'h0);
    rd_exp("R7 zero ack", 9'h028, 32'h0000_0010);
    wr(9'h02C, 32'h0000_0010);
    idle(3);
    rd_exp("R4 edge stays clear", 9'h024, 32'h0);

    // R3 / R10 / R9: level-high on pin 5
    wr(9'h144, 32'h0000_0020);
    wr(9'h034, 32'h0000_0020);
    pin_in[5] = 1'b1;
    idle(3);
    rd_exp("R3 level raw", 9'h02C, 32'h0000_0020);
    chk("R9 irq high", {31'd0, irq_o[0]}, 32'd1);
    wr(9'h02C, 32'h0000_0020);
    rd_exp("R10 clear loses to level", 9'h024, 32'h0000_0020);
    chk("R9 irq held", {31'd0, irq_o[0]}, 32'd1);
    pin_in[5] = 1'b0;
    idle(3);
    wr(9'h02C, 32'h0000_0020);
    rd_exp("R3 level gone", 9'h024, 32'h0);
    idle(1);
    chk("R9 irq low", {31'd0, irq_o[0]}, 32'd0);

    // R5: reconfigure pin 8 fall -> rise, both briefly on
    wr(9'h14C, 32'h0000_0100);
    wr(9'h148, 32'h0000_0110);
    pin_in[8] = 1'b1;
    wr(9'h14C, 32'h0);
    idle(3);
    rd_exp("R5 reconfig caught", 9'h024, 32'h0000_0100);
    wr(9'h14C, 32'h0000_0100);
    wr(9'h02C, 32'hFFFF_FFFF);
    pin_in[8] = 1'b0;
    idle(3);
    rd_exp("R5 both edges", 9'h024, 32'h0000_0100);

    // R11: raw and unmapped writes ignored
    wr(9'h024, 32'hFFFF_FFFF);
    wr(9'h100, 32'hFFFF_FFFF);
    rd_exp("R11 raw write", 9'h024, 32'h0000_0100);
    rd_exp("R11 unmapped read", 9'h100, 32'h0);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [8:0] a;
      logic [31:0] d;
      int pick;
      pin_in = pin_in ^ ($urandom & $urandom & $urandom);
      pick = int'($urandom % 13);
      if (pick < 4)       a = 9'h140 + 9'(4*pick);
      else if (pick < 12) a = 9'h024 + 9'(4*(pick-4));
      else                a = 9'h0A0;
      d = $urandom & $urandom;
      cyc(($urandom % 3) != 0, ($urandom % 2) == 0, a, d, rd);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule